// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block is a small datapath built around one shared data bus. A set of general-purpose registers and an external data input are the possible bus sources; a select code picks exactly one of them through a multiplexer, and the chosen value appears on the bus in the same cycle without any register stage.

Each register has its own load enable. On a rising clock edge, every register whose enable is high takes the bus value, and every other register keeps what it held. A single cycle can therefore broadcast one source into any subset of registers, including the source register itself. A transfer only happens when the select code and the enables are both presented in the same cycle.

Top module: `bus_xfer_unit`

## Requirements
- R1: A synchronous reset clears every register to zero at the next rising edge, and the enables are ignored while reset is high.
- R2: The bus output is combinational on the select code. Code 0 to NREG-1 (0 to 3 by default) selects register k. Code NREG (4) selects the external input `ext_din`.
- R3: Every select code above NREG (5, 6 and 7 by default) drives zero onto the bus.
- R4: At a rising edge, each register whose bit in `load_en` is high (bit k belongs to register k) takes the bus value of that cycle.
- R5: A register whose load-enable bit is low keeps its value, whatever is on the bus.
- R6: With two or more enables high, every enabled destination receives the same source value, which is the source's value from before the edge.
- R7: A register that is both the selected source and an enabled destination keeps its old value.
- R8: An unused select code with enables high loads zero into the enabled registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; loads happen on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel | input | SELW (3) | Code of the bus source |
| load_en | input | NREG (4) | Load enable for each register; bit k is register k |
| ext_din | input | W (8) | External data, selectable as a bus source |
| bus_out | output | W (8) | Current bus value |
| regs_out | output | NREG*W (32) | All register contents; register k sits in bits [k*W +: W] |

## Verification
All register contents and the live bus value are visible at the ports. A wrong load, or a register that is missed, therefore shows on `regs_out` one edge after the transfer. A wrong multiplexer decode shows on `bus_out` in the same cycle that the select code is applied. The checks read back both outputs after every transfer. A lost hold, or a destination that received the wrong source, is caught before the next transfer can hide it.

// File: rtl/bus_xfer_unit.sv
module bus_xfer_unit #(
  parameter int W    = 8,
  parameter int NREG = 4,
  parameter int SELW = $clog2(NREG + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SELW-1:0]   rd_sel,
  input  logic [NREG-1:0]   load_en,
  input  logic [W-1:0]      ext_din,
  output logic [W-1:0]      bus_out,
  output logic [NREG*W-1:0] regs_out
);
  localparam int EXT_CODE = NREG;

  logic [W-1:0] gpr [NREG];
  logic [W-1:0] bus;

  always_comb begin
    bus = '0;
    if (int'(rd_sel) < NREG) bus = gpr[rd_sel[$clog2(NREG)-1:0]];
    else if (int'(rd_sel) == EXT_CODE) bus = ext_din;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) gpr[k] <= '0;
      else if (load_en[k]) gpr[k] <= bus;
    end
    assign regs_out[k*W +: W] = gpr[k];
  end

  assign bus_out = bus;
endmodule

// File: rtl/bus_xfer_unit_chk.sv
module bus_xfer_unit_chk #(
  parameter int W    = 8,
  parameter int NREG = 4,
  parameter int SELW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [SELW-1:0]   rd_sel,
  input logic [NREG-1:0]   load_en,
  input logic [W-1:0]      ext_din,
  input logic [W-1:0]      bus_out,
  input logic [NREG*W-1:0] regs_out
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!seen) rst |=> regs_out == '0); // R1
  AST_EXT_ON_BUS: assert property (@(posedge clk) disable iff (rst) int'(rd_sel) == NREG |-> bus_out == ext_din); // R2
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst) int'(rd_sel) > NREG |-> bus_out == '0); // R3

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (rst || !seen)
      load_en[k] |=> regs_out[k*W +: W] == $past(bus_out)); // R4
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst || !seen)
      !load_en[k] |=> $stable(regs_out[k*W +: W])); // R5
  end
endmodule

bind bus_xfer_unit bus_xfer_unit_chk #(.W(W), .NREG(NREG), .SELW(SELW)) u_chk (.*);

// File: tb/tb_bus_xfer_unit.sv
module tb_bus_xfer_unit;
  localparam int W = 8, N = 4, S = 3;
  logic clk = 0, rst = 1;
  logic [S-1:0] rd_sel = 0;
  logic [N-1:0] load_en = 0;
  logic [W-1:0] ext_din = 0;
  logic [W-1:0] bus_out;
  logic [N*W-1:0] regs_out;
  int total = 0, bad = 0;
  logic [W-1:0] model [N];

  bus_xfer_unit dut (.*);
  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    for (int k = 0; k < N; k++) chk(req, regs_out[k*W +: W], model[k]);
  endtask

  task automatic xfer(logic [S-1:0] s, logic [N-1:0] en, logic [W-1:0] d, string req);
    logic [W-1:0] b;
    @(negedge clk);
    rd_sel = s; load_en = en; ext_din = d;
    #1;
    b = (s < N) ? model[s] : (s == N ? d : '0);
    chk(req, bus_out, b);
    @(posedge clk);
    for (int k = 0; k < N; k++) if (en[k]) model[k] = b;
    @(negedge clk);
    load_en = 0;
    check_regs(req);
  endtask

  task automatic t_reset();
    // R1
    rst = 1; load_en = '1; rd_sel = 4; ext_din = 8'hAA;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < N; k++) model[k] = 0;
    check_regs("R1");
    rst = 0; load_en = 0;
  endtask

  task automatic t_ext_load();
    // R2 and R4
    xfer(4, 4'b0001, 8'h11, "R4");
    xfer(4, 4'b0010, 8'h22, "R4");
    xfer(4, 4'b0100, 8'h33, "R2");
    xfer(4, 4'b1000, 8'h44, "R2");
  endtask

  task automatic t_reg_sources();
    // R2: each register code puts that register on the bus
    for (int k = 0; k < N; k++) begin
      @(negedge clk); rd_sel = S'(k); load_en = 0; #1;
      chk("R2", bus_out, model[k]);
    end
  endtask

  task automatic t_broadcast();
    xfer(1, 4'b1001, 8'h00, "R6");
    xfer(2, 4'b1011, 8'h00, "R6");
  endtask

  task automatic t_self();
    xfer(0, 4'b0001, 8'hFF, "R7");
    xfer(3, 4'b1100, 8'hFF, "R7");
  endtask

  task automatic t_hold();
    // R5: the bus changes but every enable is low
    xfer(4, 4'b0000, 8'h5A, "R5");
    xfer(0, 4'b0000, 8'hC3, "R5");
  endtask

  task automatic t_unused();
    xfer(4, 4'b1111, 8'h77, "R4");
    for (int c = 5; c < 8; c++) begin
      @(negedge clk); rd_sel = S'(c); ext_din = 8'hEE; #1;
      chk("R3", bus_out, 0);
    end
    xfer(6, 4'b0101, 8'hEE, "R8");
    xfer(7, 4'b1010, 8'hEE, "R8");
  endtask

  initial begin
    t_reset();
    t_ext_load();
    t_reg_sources();
    t_broadcast();
    t_self();
    t_hold();
    t_unused();
    xfer(4, 4'b0110, 8'h9C, "R4");
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule